// File: doc/BRIEF.md
# Mains-Synchronised Stepper Clock Driver

This block turns the pulse train from a full-wave rectified mains supply into drive for the stepping coil of an analogue clock movement. A full-wave rectifier passes both half-cycles, so the pulse rate is twice the mains frequency. The block brings the raw pulses into the system clock domain and counts only their rising edges. It divides that count down to one event per second. On each second it sends a short pulse to one of two coil outputs, and it uses the other output on the next second. The coil therefore sees reversed polarity on every step.

Long-term accuracy comes from the mains frequency, not from a crystal. Each output is active only inside a window of a few mains ticks, so the coil is never held energised for a whole second. All pins are plain control signals. The block carries no data stream and applies no back-pressure. A single-cycle tick marks each second boundary so that surrounding logic or a bench can observe it.

Top module: `mains_step_driver`

## Requirements
- R1: While `rst` is high at a clock edge, `coil_a`, `coil_b` and `sec_tick` are low after that edge. After reset the edge count restarts from zero, and the first step drives `coil_a`.
- R2: The input passes through two synchronising flops. One input high level is counted exactly once, however many system clocks it lasts.
- R3: The number of counted edges per second is 2*MAINS_HZ: 100 when MAINS_HZ is 50 and 120 when MAINS_HZ is 60. It is built as a divide-by-10 stage followed by a divide-by-(2*MAINS_HZ/10) stage.
- R4: `sec_tick` is high for exactly one system clock on every edge count that is a multiple of 2*MAINS_HZ (that is, after edge 2*MAINS_HZ, 4*MAINS_HZ, ...). It rises three system clock edges after the input rising edge that completes the second.
- R5: A coil pulse starts in the same cycle as `sec_tick` and stays high through PULSE_TICKS counted input edges, counting the edge that started it. It falls on the next counted edge after those.
- R6: Steps alternate. Odd-numbered seconds since reset drive `coil_a`, and even-numbered seconds drive `coil_b`.
- R7: `coil_a` and `coil_b` are never high in the same cycle.
- R8: Outside the pulse windows of R5, both coil outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mains_in | input | 1 | Raw rectified mains pulses, asynchronous |
| coil_a | output | 1 | Drive for coil end A, active high |
| coil_b | output | 1 | Drive for coil end B, active high |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |

## Verification
The bench feeds the same pulse stream to a 50 Hz instance with a three-tick pulse and to a 60 Hz instance with a one-tick pulse. The two divide ratios and the two pulse widths must each come out right. The high and low widths of the mains pulses rotate through several values, so a miscounted or double-counted edge would shift every later step. Some pulses are held high for many clocks to show that a long level still counts once. The count is also reset in the middle of a second, and the next step must again land on `coil_a` after a full second.

// File: rtl/msd_pkg.sv
package msd_pkg;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } coil_side_e;

  // Counted edges per second: both half-cycles are rectified.
  function automatic int unsigned ticks_per_sec(int unsigned hz);
    return 2 * hz;
  endfunction

  // Modulus of divider stage idx: a decade first, the remainder second.
  function automatic int unsigned stage_mod(int unsigned hz, int unsigned idx);
    return (idx == 0) ? 10 : (2 * hz) / 10;
  endfunction

endpackage

// File: rtl/msd_edge_sync.sv
module msd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic s_meta, s_sync, s_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= async_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  assign rise = s_sync & ~s_prev;

  // R2: one level produces a single-cycle count strobe
  p_single_count_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/msd_mod_counter.sv
module msd_mod_counter #(
  parameter int unsigned MOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic last
);
  localparam int unsigned W = (MOD > 1) ? $clog2(MOD) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (en)   cnt <= last ? '0 : cnt + 1'b1;
  end

  assign last = (cnt == W'(MOD - 1));

  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} < (W+1)'(MOD));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (en && last) |=> (cnt == '0));

endmodule

// File: rtl/msd_second_div.sv
module msd_second_div
  import msd_pkg::*;
#(
  parameter int unsigned MAINS_HZ = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_in,
  output logic wrap,
  output logic sec_tick
);
  localparam int unsigned NSTAGE = 2;

  logic [NSTAGE-1:0] stage_en;
  logic [NSTAGE-1:0] stage_last;

  assign stage_en[0] = edge_in;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    msd_mod_counter #(.MOD(stage_mod(MAINS_HZ, g))) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .en   (stage_en[g]),
      .last (stage_last[g])
    );
    if (g < NSTAGE - 1) begin : g_carry
      assign stage_en[g+1] = stage_en[g] & stage_last[g];
    end
  end

  assign wrap = edge_in & (&stage_last);

  always_ff @(posedge clk) begin
    if (rst) sec_tick <= 1'b0;
    else     sec_tick <= wrap;
  end

  p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);

endmodule

// File: rtl/msd_step_gate.sv
module msd_step_gate
  import msd_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_in,
  input  logic wrap,
  output logic coil_a,
  output logic coil_b
);
  localparam int unsigned PW_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

  coil_side_e      next_side, cur_side;
  logic            active;
  logic [PW_W-1:0] pw;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_side <= SIDE_A;
      cur_side  <= SIDE_A;
      active    <= 1'b0;
      pw        <= '0;
    end else if (wrap) begin
      cur_side  <= next_side;
      next_side <= (next_side == SIDE_A) ? SIDE_B : SIDE_A;
      active    <= 1'b1;
      pw        <= '0;
    end else if (active && edge_in) begin
      if (pw == PW_W'(PULSE_TICKS - 1)) active <= 1'b0;
      else                             pw     <= pw + 1'b1;
    end
  end

  assign coil_a = active && (cur_side == SIDE_A);
  assign coil_b = active && (cur_side == SIDE_B);

  // R6: the side used by a step is the one queued before it, and the queue flips
  p_side_flip_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cur_side != next_side));

  // R5: a pulse only opens on a second boundary
  p_open_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(wrap));

  p_width_bound_r5: assert property (@(posedge clk) disable iff (rst)
    active |-> ({1'b0, pw} < (PW_W+1)'(PULSE_TICKS)));

endmodule

// File: rtl/mains_step_driver.sv
module mains_step_driver
  import msd_pkg::*;
#(
  parameter int unsigned MAINS_HZ    = 50,
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mains_in,
  output logic coil_a,
  output logic coil_b,
  output logic sec_tick
);
  logic edge_pulse;
  logic wrap;

  msd_edge_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (mains_in),
    .rise     (edge_pulse)
  );

  msd_second_div #(.MAINS_HZ(MAINS_HZ)) u_div (
    .clk      (clk),
    .rst      (rst),
    .edge_in  (edge_pulse),
    .wrap     (wrap),
    .sec_tick (sec_tick)
  );

  msd_step_gate #(.PULSE_TICKS(PULSE_TICKS)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .edge_in (edge_pulse),
    .wrap    (wrap),
    .coil_a  (coil_a),
    .coil_b  (coil_b)
  );

  p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(coil_a && coil_b));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!coil_a && !coil_b && !sec_tick));

  p_step_with_tick_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(coil_a) || $rose(coil_b)) |-> sec_tick);

endmodule

// File: tb/mains_step_driver_test.sv
module mains_step_driver_test;

  localparam int R50 = 100, P50 = 3;
  localparam int R60 = 120, P60 = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mains = 1'b0;
  logic a50, b50, t50, a60, b60, t60;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mains_step_driver #(.MAINS_HZ(50), .PULSE_TICKS(P50)) uut (
    .clk(clk), .rst(rst), .mains_in(mains),
    .coil_a(a50), .coil_b(b50), .sec_tick(t50));

  mains_step_driver #(.MAINS_HZ(60), .PULSE_TICKS(P60)) uut_b (
    .clk(clk), .rst(rst), .mains_in(mains),
    .coil_a(a60), .coil_b(b60), .sec_tick(t60));

  task automatic expect_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, n);
    end
  endtask

  function automatic int exp_coil(int cnt, int r, int p, bit side_b);
    if (cnt < r || (cnt % r) >= p) return 0;
    return (((cnt / r) % 2) == (side_b ? 0 : 1)) ? 1 : 0;
  endfunction

  // One mains pulse: hi system clocks high, lo low; drives at negedge.
  task automatic mains_pulse(int hi, int lo);
    int t50c = 0, t60c = 0;
    mains = 1'b1;
    for (int i = 0; i < hi; i++) begin
      @(negedge clk); t50c += int'(t50); t60c += int'(t60);
    end
    mains = 1'b0;
    for (int i = 0; i < lo; i++) begin
      @(negedge clk); t50c += int'(t50); t60c += int'(t60);
    end
    n++;
    expect_val(hi > 10 ? "R2 long level sec_tick 50" : "R4 sec_tick 50",
               t50c, (n % R50 == 0) ? 1 : 0);
    expect_val("R3 sec_tick 60", t60c, (n % R60 == 0) ? 1 : 0);
    expect_val(exp_coil(n, R50, P50, 0) != 0 ? "R5 coil_a 50" : "R8 coil_a 50",
               int'(a50), exp_coil(n, R50, P50, 0));
    expect_val("R6 coil_b 50", int'(b50), exp_coil(n, R50, P50, 1));
    expect_val("R3 coil_a 60", int'(a60), exp_coil(n, R60, P60, 0));
    expect_val("R6 coil_b 60", int'(b60), exp_coil(n, R60, P60, 1));
    expect_val("R7 exclusive", int'((a50 && b50) || (a60 && b60)), 0);
  endtask

  task automatic run_edges(int count);
    for (int k = 0; k < count; k++) begin
      int hi = ((n + 1) % 25 == 0) ? 30 : 1 + (n % 6);
      int lo = 3 + (n % 4);
      mains_pulse(hi, lo);
    end
  endtask

  task automatic reset_phase(int cycles);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      mains = (i % 4) < 2;
      @(negedge clk);
      if (i > 0) begin
        expect_val("R1 reset coils", int'(a50 | b50 | a60 | b60), 0);
        expect_val("R1 reset tick", int'(t50 | t60), 0);
      end
    end
    mains = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    n = 0;
  endtask

  initial begin
    @(negedge clk);
    reset_phase(12);
    run_edges(150);           // first step on coil_a, mid-second at the end
    reset_phase(6);           // R1: restart from a partial second
    run_edges(250);           // A, B at 50 Hz; A, B at 60 Hz
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule